// File: doc/BRIEF.md
# Sprite Fetch Address Generator

This block turns a sprite fetch request into a 14-bit video memory address for the tiled display mode. A fetch is one of four kinds. Three read the sprite attribute table: the vertical position byte, the horizontal position byte and the tile number byte of one of 64 sprites. The fourth reads one bitplane byte of one line of a sprite pattern from the pattern table. The caller gives the kind, the sprite index or tile coordinates, and the current images of the two table base registers. One clock later the block returns the address with a valid strobe.

Two chip variants are supported. On the older variant, low bits of the base registers act as gates on single address lines. A cleared gate bit forces its address line to zero, so parts of a table alias onto other parts. On the newer variant those bits have no effect, and every address line follows its source.

Top module: `sprfetch_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `addr_valid` = 0 and `addr` = 0.
- R2: `addr_valid` is 1 exactly in the cycle after a cycle with `req` high and is 0 otherwise. The address captured on that request appears on `addr` in the same cycle.
- R3: Kind code 0 (vertical position) gives addr[13:8] = `attr_base[6:1]`, addr[7] = 0, addr[6:1] = sprite index and addr[0] = 0.
- R4: Kind code 1 (horizontal position) gives the same layout as R3 but with addr[7] = 1 (subject to R6) and addr[0] = 0.
- R5: Kind code 2 (tile number) gives the R4 layout with addr[0] = 1.
- R6: When `legacy` = 1, addr[7] of kind 1 and kind 2 equals `attr_base[0]`. A cleared bit folds these fetches into the lower half of the table.
- R7: Kind code 3 (pattern byte) gives addr[13] = `pat_base[2]`, addr[12:5] = tile number, addr[4:2] = tile line and addr[1:0] = bitplane select.
- R8: When `legacy` = 1, addr[12] of a pattern fetch is ANDed with `pat_base[1]` and addr[11] with `pat_base[0]`. This limits the reachable tiles to 128 or 64.
- R9: When `legacy` = 0, `attr_base[0]`, `pat_base[1]` and `pat_base[0]` have no effect on any address.
- R10: In a cycle with no request, `addr` keeps its previous value.
- R11: With `attr_base` all ones and sprite 0, a vertical-position fetch gives address 0x3F00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Fetch request strobe |
| kind | input | 2 | Fetch kind: 0 vertical, 1 horizontal, 2 tile number, 3 pattern byte |
| spr_idx | input | 6 | Sprite index, 0 to 63 |
| tile_num | input | 8 | Tile number for pattern fetch |
| tile_row | input | 3 | Line within the tile |
| plane | input | 2 | Bitplane select |
| attr_base | input | 7 | Attribute base: bits 6:1 table base, bit 0 gate bit |
| pat_base | input | 3 | Pattern base: bit 2 table base, bits 1:0 gate bits |
| legacy | input | 1 | 1 selects the older variant with gate bits active |
| addr_valid | output | 1 | Address valid, one cycle after `req` |
| addr | output | 14 | Registered fetch address |

## Verification
The assertions assume that `rst` is asserted from time zero and that every request input is stable around the sampling edge. They also assume that `kind` holds one of the four defined codes, which a 2-bit port always does. The bench changes all inputs only on the falling edge. It keeps `rst` high for the opening cycles and drives every field with known values, so each clocked property sees defined data. Directed sequences cover the all-ones base, the index extremes and every gate bit combination on both variants. A randomized run then mixes request gaps with all four kinds.

// File: rtl/sprfetch_pkg.sv
package sprfetch_pkg;

    localparam int ADDR_W   = 14;
    localparam int IDX_W    = 6;
    localparam int TILE_W   = 8;
    localparam int ROW_W    = 3;
    localparam int PLANE_W  = 2;
    localparam int ABASE_W  = 6;
    localparam int PBASE_W  = 1;
    localparam int PMASK_N  = 2;
    localparam int AREG_W   = ABASE_W + 1;
    localparam int PREG_W   = PBASE_W + PMASK_N;
    localparam int PAT_HI   = ADDR_W - PBASE_W - 1;

    typedef enum logic [1:0] {
        FK_YPOS  = 2'd0,
        FK_XPOS  = 2'd1,
        FK_TILE  = 2'd2,
        FK_PLANE = 2'd3
    } fetch_kind_e;

    typedef enum logic {
        VAR_NEW = 1'b0,
        VAR_OLD = 1'b1
    } chip_var_e;

    typedef struct packed {
        logic [ABASE_W-1:0] base;
        logic               half;
        logic [IDX_W-1:0]   idx;
        logic               field;
    } attr_addr_s;

    typedef struct packed {
        logic [PBASE_W-1:0] base;
        logic [TILE_W-1:0]  tile;
        logic [ROW_W-1:0]   row;
        logic [PLANE_W-1:0] plane;
    } pat_addr_s;

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  addr;
    } fetch_out_s;

    function automatic logic gate_line(input logic line, input logic gate_bit,
                                       input chip_var_e variant);
        return line & (gate_bit | (variant == VAR_NEW));
    endfunction

endpackage

// File: rtl/sprfetch_attr_gen.sv
module sprfetch_attr_gen
    import sprfetch_pkg::*;
(
    input  fetch_kind_e              kind,
    input  chip_var_e                variant,
    input  logic [IDX_W-1:0]         spr_idx,
    input  logic [AREG_W-1:0]        attr_base,
    output logic [ADDR_W-1:0]        addr
);
    attr_addr_s a;
    logic       second_half;

    always_comb begin
        second_half = (kind != FK_YPOS);
        a.base  = attr_base[AREG_W-1:1];
        a.half  = gate_line(second_half, attr_base[0], variant);
        a.idx   = spr_idx;
        a.field = (kind == FK_TILE);
        addr    = a;
    end
endmodule

// File: rtl/sprfetch_pat_gen.sv
module sprfetch_pat_gen
    import sprfetch_pkg::*;
(
    input  chip_var_e                variant,
    input  logic [TILE_W-1:0]        tile_num,
    input  logic [ROW_W-1:0]         tile_row,
    input  logic [PLANE_W-1:0]       plane,
    input  logic [PREG_W-1:0]        pat_base,
    output logic [ADDR_W-1:0]        addr
);
    localparam int TOP_T = TILE_W - 1;

    logic [TILE_W-1:0] tile_gated;
    pat_addr_s         p;

    genvar g;
    generate
        for (g = 0; g < TILE_W; g++) begin : g_tile
            if (g >= TILE_W - PMASK_N) begin : g_gated
                assign tile_gated[g] = gate_line(tile_num[g],
                    pat_base[g - (TILE_W - PMASK_N)], variant);
            end else begin : g_plain
                assign tile_gated[g] = tile_num[g];
            end
        end
    endgenerate

    always_comb begin
        p.base  = pat_base[PREG_W-1 -: PBASE_W];
        p.tile  = tile_gated;
        p.row   = tile_row;
        p.plane = plane;
        addr    = p;
    end
endmodule

// File: rtl/sprfetch_out_reg.sv
module sprfetch_out_reg
    import sprfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] next_addr,
    output fetch_out_s        q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= req;
            if (req) q.addr <= next_addr;
        end
    end

    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        req |=> q.valid);
    p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !req |=> !q.valid);
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(q.addr));
endmodule

// File: rtl/sprfetch_addr_gen.sv
module sprfetch_addr_gen
    import sprfetch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [1:0]           kind,
    input  logic [IDX_W-1:0]     spr_idx,
    input  logic [TILE_W-1:0]    tile_num,
    input  logic [ROW_W-1:0]     tile_row,
    input  logic [PLANE_W-1:0]   plane,
    input  logic [AREG_W-1:0]    attr_base,
    input  logic [PREG_W-1:0]    pat_base,
    input  logic                 legacy,
    output logic                 addr_valid,
    output logic [ADDR_W-1:0]    addr
);
    fetch_kind_e       k;
    chip_var_e         variant;
    logic [ADDR_W-1:0] attr_addr;
    logic [ADDR_W-1:0] pat_addr;
    logic [ADDR_W-1:0] next_addr;
    fetch_out_s        q;

    assign k       = fetch_kind_e'(kind);
    assign variant = chip_var_e'(legacy);

    sprfetch_attr_gen u_attr (
        .kind      (k),
        .variant   (variant),
        .spr_idx   (spr_idx),
        .attr_base (attr_base),
        .addr      (attr_addr)
    );

    sprfetch_pat_gen u_pat (
        .variant   (variant),
        .tile_num  (tile_num),
        .tile_row  (tile_row),
        .plane     (plane),
        .pat_base  (pat_base),
        .addr      (pat_addr)
    );

    always_comb begin
        next_addr = (k == FK_PLANE) ? pat_addr : attr_addr;
    end

    sprfetch_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .next_addr (next_addr),
        .q         (q)
    );

    assign addr_valid = q.valid;
    assign addr       = q.addr;

    p_ypos_layout_r3: assert property (@(posedge clk) disable iff (rst)
        (req && kind == 2'd0) |=> (!addr[7] && !addr[0]
            && addr[6:1] == $past(spr_idx) && addr[13:8] == $past(attr_base[6:1])));
    p_xpos_low_r4: assert property (@(posedge clk) disable iff (rst)
        (req && kind == 2'd1) |=> !addr[0]);
    p_tile_low_r5: assert property (@(posedge clk) disable iff (rst)
        (req && kind == 2'd2) |=> addr[0]);
    p_old_attr_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (req && legacy && kind != 2'd3 && !attr_base[0]) |=> !addr[7]);
    p_pat_fields_r7: assert property (@(posedge clk) disable iff (rst)
        (req && kind == 2'd3) |=> (addr[1:0] == $past(plane)
            && addr[4:2] == $past(tile_row) && addr[13] == $past(pat_base[2])));
    p_old_pat_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (req && legacy && kind == 2'd3 && !pat_base[0]) |=> !addr[11]);
    p_new_no_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (req && !legacy && kind == 2'd3) |=> addr[12:5] == $past(tile_num));
endmodule

// File: tb/sprfetch_addr_gen_bench.sv
module sprfetch_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  kind = '0;
    logic [5:0]  spr_idx = '0;
    logic [7:0]  tile_num = '0;
    logic [2:0]  tile_row = '0;
    logic [1:0]  plane = '0;
    logic [6:0]  attr_base = '0;
    logic [2:0]  pat_base = '0;
    logic        legacy = 1'b0;
    logic        addr_valid;
    logic [13:0] addr;

    int checks = 0;
    int errors = 0;
    int ref_addr = 0;
    bit done = 0;
    int exp_q[$];
    int val_q[$];

    always #10 clk = ~clk;

    sprfetch_addr_gen u_sprfetch_addr_gen (
        .clk(clk), .rst(rst), .req(req), .kind(kind), .spr_idx(spr_idx),
        .tile_num(tile_num), .tile_row(tile_row), .plane(plane),
        .attr_base(attr_base), .pat_base(pat_base), .legacy(legacy),
        .addr_valid(addr_valid), .addr(addr)
    );

    function automatic int model_addr(int k, int idx, int t, int row, int pl,
                                      int ab, int pb, int old);
        int a;
        if (k == 3) begin
            a = ((pb >> 2) & 1) * 8192 + t * 32 + row * 4 + pl;
            if (old != 0 && (pb & 2) == 0) a = a & ~4096;
            if (old != 0 && (pb & 1) == 0) a = a & ~2048;
        end else begin
            a = ((ab >> 1) & 63) * 256 + idx * 2;
            if (k != 0) begin
                if (old == 0 || (ab & 1) != 0) a = a + 128;
            end
            if (k == 2) a = a + 1;
        end
        return a;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit r, input int k, input int idx, input int t,
                        input int row, input int pl, input int ab, input int pb,
                        input int old, input string tag);
        req = r; kind = 2'(k); spr_idx = 6'(idx); tile_num = 8'(t);
        tile_row = 3'(row); plane = 2'(pl); attr_base = 7'(ab);
        pat_base = 3'(pb); legacy = old[0];
        if (r) ref_addr = model_addr(k, idx, t, row, pl, ab, pb, old);
        exp_q.push_back(ref_addr);
        val_q.push_back(int'(r));
        @(negedge clk);
        check({tag, " R2 valid"}, int'(addr_valid), val_q.pop_front());
        check(tag, int'(addr), exp_q.pop_front());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", int'(addr_valid), 0);
        check("R1 addr", int'(addr), 0);
        rst = 1'b0;
        step(1, 0, 0, 0, 0, 0, 127, 7, 0, "R11 ypos all ones");
        step(1, 0, 63, 0, 0, 0, 85, 7, 1, "R3 ypos idx63");
        step(1, 1, 63, 0, 0, 0, 127, 7, 0, "R4 xpos idx63");
        step(1, 1, 5, 0, 0, 0, 42, 7, 0, "R4 xpos base42");
        step(1, 2, 17, 0, 0, 0, 127, 7, 0, "R5 tile idx17");
        step(1, 1, 9, 0, 0, 0, 126, 7, 1, "R6 old xpos gated");
        step(1, 2, 40, 0, 0, 0, 126, 7, 1, "R6 old tile gated");
        step(1, 2, 40, 0, 0, 0, 127, 7, 1, "R6 old tile open");
        step(1, 3, 0, 255, 7, 3, 0, 7, 0, "R7 pattern max");
        step(1, 3, 0, 170, 2, 1, 0, 3, 0, "R7 pattern low base");
        step(1, 3, 0, 255, 7, 3, 0, 6, 1, "R8 old gate bit0");
        step(1, 3, 0, 255, 7, 3, 0, 5, 1, "R8 old gate bit1");
        step(1, 3, 0, 255, 5, 2, 0, 4, 1, "R8 old both gates");
        step(1, 3, 0, 255, 5, 2, 0, 4, 0, "R9 new pattern ungated");
        step(1, 2, 33, 0, 0, 0, 126, 7, 0, "R9 new tile ungated");
        step(0, 0, 1, 1, 1, 1, 0, 0, 1, "R10 hold");
        step(0, 3, 2, 2, 2, 2, 3, 1, 0, "R10 hold again");
        step(1, 0, 12, 0, 0, 0, 100, 0, 0, "R3 ypos after gap");
        for (int n = 0; n < 400; n++) begin
            int k;
            k = int'($urandom_range(3));
            step($urandom_range(3) != 0, k, int'($urandom_range(63)),
                 int'($urandom_range(255)), int'($urandom_range(7)),
                 int'($urandom_range(3)), int'($urandom_range(127)),
                 int'($urandom_range(7)), int'($urandom_range(1)),
                 k == 3 ? "R7 R8 random" : "R3 R4 R5 R6 random");
        end
        rst = 1'b1;
        req = 1'b1;
        exp_q.delete();
        val_q.delete();
        @(negedge clk);
        check("R1 valid in reset", int'(addr_valid), 0);
        check("R1 addr in reset", int'(addr), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule